// File: doc/BRIEF.md
# Latched 3-to-8 Inverting Decoder

This block turns a 3-bit binary address into eight mutually exclusive active-low select lines. A level-sensitive address latch stands in front of a purely combinational decoder. While the hold control is low the latch is transparent, so the outputs track the live address. When the hold control rises, the latch keeps the address it saw just before the edge, and the outputs ignore later address changes until the hold control drops again.

A pair of output enables of opposite polarity gates the outputs after the decoder. Every output is high unless the active-low enable is low and the active-high enable is high at the same time. The gate works the same way whether the latch is open or holding, and it never disturbs the stored address. The block has no clock. It is meant for select or strobe fan-out where an address is set up once and then frozen.

Top module: `addr_latch_decoder`

## Requirements
- R1: With both enables asserted (en_n_i = 0, en_i = 1), output bit number k of y_n_o is low and the other seven bits are high, where k is the held address read as an unsigned binary number with addr_i[0] as its least significant bit.
- R2: At no time is more than one bit of y_n_o low.
- R3: While le_i is low, the outputs follow every change of addr_i.
- R4: On a rising edge of le_i, the address present on addr_i just before that edge is stored, and the outputs show it.
- R5: While le_i stays high, changes on addr_i have no effect on y_n_o.
- R6: y_n_o is all ones for the three enable pairs (en_n_i, en_i) = (1,0), (1,1) and (0,0). Only (0,1) lets a decoded line go low.
- R7: The enable gate acts while le_i is high as well. Turning the outputs off and then on again with le_i still high shows the stored address again.
- R8: When le_i returns low, the outputs again follow the live address.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| addr_i | input | 3 | Binary address, bit 0 least significant |
| le_i | input | 1 | Hold control: low = transparent, high = hold |
| en_n_i | input | 1 | Output enable, active low |
| en_i | input | 1 | Output enable, active high |
| y_n_o | output | 8 | Active-low select lines |

## Verification
Every result is due in the same cycle as its stimulus. The path from any input to y_n_o runs through a transparent latch and combinational gates only, with no register. The bench therefore changes inputs on the rising edge of its pacing clock and samples y_n_o on the following falling edge, half a period later, when the outputs have settled. The bench never changes the address in the same step as a rising edge of le_i. Because of this, the value it expects to be captured is always the address already applied before that step.

// File: rtl/adl_pkg.sv
package adl_pkg;

    typedef enum logic {
        GATE_SHUT = 1'b0,
        GATE_OPEN = 1'b1
    } gate_state_e;

    // Enable pair decode: open only for active-low low and active-high high.
    function automatic gate_state_e gate_of(input logic en_n, input logic en);
        return (!en_n && en) ? GATE_OPEN : GATE_SHUT;
    endfunction

endpackage

// File: rtl/adl_addr_latch.sv
module adl_addr_latch #(
    parameter int ADDR_W = 3
) (
    input  logic [ADDR_W-1:0] addr_d,
    input  logic              hold_i,
    output logic [ADDR_W-1:0] addr_q
);

    // Level-sensitive storage: transparent while hold is low.
    always_latch begin
        if (!hold_i) begin
            addr_q <= addr_d;
        end
    end

endmodule

// File: rtl/adl_onehot_dec.sv
module adl_onehot_dec #(
    parameter int ADDR_W = 3,
    parameter int OUT_N  = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr_q,
    output logic [OUT_N-1:0]  hot_d
);

    for (genvar i = 0; i < OUT_N; i++) begin : g_line
        assign hot_d[i] = (addr_q == ADDR_W'(i));
    end

endmodule

// File: rtl/adl_out_gate.sv
module adl_out_gate #(
    parameter int OUT_N = 8
) (
    input  logic [OUT_N-1:0] hot_d,
    input  logic             en_n_i,
    input  logic             en_i,
    output logic [OUT_N-1:0] y_n_o
);

    import adl_pkg::*;

    gate_state_e gate_d;

    always_comb begin
        gate_d = gate_of(en_n_i, en_i);
        if (gate_d == GATE_OPEN) begin
            y_n_o = ~hot_d;
        end else begin
            y_n_o = '1;
        end
    end

endmodule

// File: rtl/addr_latch_decoder.sv
module addr_latch_decoder #(
    parameter int ADDR_W = 3,
    localparam int OUT_N = 1 << ADDR_W
) (
    input  logic [ADDR_W-1:0] addr_i,
    input  logic              le_i,
    input  logic              en_n_i,
    input  logic              en_i,
    output logic [OUT_N-1:0]  y_n_o
);

    logic [ADDR_W-1:0] addr_q;
    logic [OUT_N-1:0]  hot_d;

    adl_addr_latch #(
        .ADDR_W (ADDR_W)
    ) latch_i (
        .addr_d (addr_i),
        .hold_i (le_i),
        .addr_q (addr_q)
    );

    adl_onehot_dec #(
        .ADDR_W (ADDR_W),
        .OUT_N  (OUT_N)
    ) dec_i (
        .addr_q (addr_q),
        .hot_d  (hot_d)
    );

    adl_out_gate #(
        .OUT_N (OUT_N)
    ) gate_i (
        .hot_d  (hot_d),
        .en_n_i (en_n_i),
        .en_i   (en_i),
        .y_n_o  (y_n_o)
    );

endmodule

// File: rtl/addr_latch_decoder_chk.sv
module addr_latch_decoder_chk #(
    parameter int ADDR_W = 3,
    localparam int OUT_N = 1 << ADDR_W
) (
    input logic [ADDR_W-1:0] addr_i,
    input logic              le_i,
    input logic              en_n_i,
    input logic              en_i,
    input logic [OUT_N-1:0]  y_n_o
);

    function automatic logic [OUT_N-1:0] low_line(input logic [ADDR_W-1:0] a);
        logic [OUT_N-1:0] v;
        v = '1;
        v[a] = 1'b0;
        return v;
    endfunction

    logic [ADDR_W-1:0] cap_q;
    bit                seen_rise = 1'b0;

    // Independent record of the address seen at each hold edge.
    always @(posedge le_i) begin
        cap_q     <= addr_i;
        seen_rise <= 1'b1;
    end

    // R2: one low line at most, sampled at both hold edges.
    p_onehot_rise_r2: assert property (@(posedge le_i)
        $countones(~y_n_o) <= 1);
    p_onehot_fall_r2: assert property (@(negedge le_i)
        $countones(~y_n_o) <= 1);

    // R6: outputs are all high unless the enable pair is (0,1).
    p_gate_shut_r6: assert property (@(posedge le_i)
        !(!en_n_i && en_i) |-> (y_n_o == '1));

    // R3: just before the hold edge, outputs track the live address.
    p_follow_r3: assert property (@(posedge le_i)
        (!en_n_i && en_i) |-> (y_n_o == low_line(addr_i)));

    // R4, R5: just before release, outputs show the captured address.
    p_hold_r4: assert property (@(negedge le_i)
        (seen_rise && !en_n_i && en_i) |-> (y_n_o == low_line(cap_q)));

endmodule

bind addr_latch_decoder addr_latch_decoder_chk #(.ADDR_W(ADDR_W)) chk_i (
    .addr_i (addr_i),
    .le_i   (le_i),
    .en_n_i (en_n_i),
    .en_i   (en_i),
    .y_n_o  (y_n_o)
);

// File: tb/addr_latch_decoder_tb_top.sv
module addr_latch_decoder_tb_top;

    logic       clk = 1'b0;
    logic [2:0] addr;
    logic       le;
    logic       en_n;
    logic       en;
    logic [7:0] y_n;

    int total = 0;
    int bad   = 0;

    logic [2:0] held;

    always #4 clk = ~clk;

    addr_latch_decoder dut_i (
        .addr_i (addr),
        .le_i   (le),
        .en_n_i (en_n),
        .en_i   (en),
        .y_n_o  (y_n)
    );

    function automatic logic [7:0] ref_y(input logic [2:0] a, input logic n, input logic p);
        if (!n && p) return ~(8'd1 << a);
        return 8'hFF;
    endfunction

    task automatic drive(input logic [2:0] a, input logic l, input logic n, input logic p);
        @(posedge clk);
        addr = a;
        le   = l;
        en_n = n;
        en   = p;
        if (!l) held = a;
    endtask

    task automatic check(input string req);
        logic [7:0] exp;
        @(negedge clk);
        exp = ref_y(le ? held : addr, en_n, en);
        total++;
        if (y_n !== exp) begin
            bad++;
            $display("FAIL %s: y_n=%b expected=%b", req, y_n, exp);
        end
        total++;
        if ($countones(~y_n) > 1) begin
            bad++;
            $display("FAIL R2: y_n=%b expected at most one low bit", y_n);
        end
    endtask

    initial begin
        addr = 3'd0; le = 1'b0; en_n = 1'b1; en = 1'b0; held = 3'd0;
        check("R6 idle state");

        // R1, R3: transparent sweep with outputs enabled
        for (int a = 0; a < 8; a++) begin
            drive(3'(a), 1'b0, 1'b0, 1'b1);
            check("R1 R3 transparent decode");
        end

        // R6: every enable pair on every address
        for (int a = 0; a < 8; a++) begin
            for (int g = 0; g < 4; g++) begin
                drive(3'(a), 1'b0, g[1], g[0]);
                check("R6 enable pair");
            end
        end

        // R4 then R5: hold each address and disturb the input
        for (int h = 0; h < 8; h++) begin
            drive(3'(h), 1'b0, 1'b0, 1'b1);
            check("R3 setup");
            drive(3'(h), 1'b1, 1'b0, 1'b1);
            check("R4 captured address");
            for (int a = 0; a < 8; a++) begin
                drive(3'(a), 1'b1, 1'b0, 1'b1);
                check("R5 address ignored while held");
            end
            drive(~3'(h), 1'b0, 1'b0, 1'b1);
            check("R8 release follows live address");
        end

        // R7: gate while holding, then reopen
        drive(3'd5, 1'b0, 1'b0, 1'b1);
        check("R3 setup");
        drive(3'd5, 1'b1, 1'b0, 1'b1);
        check("R4 captured address");
        for (int g = 0; g < 4; g++) begin
            drive(3'(g + 1), 1'b1, g[1], g[0]);
            check("R7 gate while holding");
            drive(3'(g + 2), 1'b1, 1'b0, 1'b1);
            check("R7 reopen shows stored address");
        end
        drive(3'd2, 1'b0, 1'b0, 1'b1);
        check("R8 release follows live address");

        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

    initial begin
        repeat (100000) @(posedge clk);
        bad++;
        $display("FAIL watchdog: run did not end, expected completion");
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end

endmodule